// File: doc/BRIEF.md
# MII Management Frame Register Handler

This block gives a host a register-mapped path to the management registers of an on-chip PHY model. The host writes a 32-bit management frame word. The block decodes the frame and either writes or reads one of a small bank of 16-bit PHY registers. It then stores the word back with the turnaround-complete flag raised. For a read, the word also carries the register contents in its data field. The host polls the same word to collect the result.

The PHY model applies the usual side effects of the MII control register. A soft reset request self-clears and turns on auto-negotiation. A negotiation restart self-clears, marks negotiation complete, and reports link and partner ability when the link is up. A link-up input is tracked, and every change of it after start-up raises a 16-bit interrupt status. That status clears on read and, together with a mask, drives one interrupt line. A small configuration register holds two read-only transceiver-select bits.

Top module: `mgmt_frame_regs`

## Requirements
- R1: A frame word written to register index 0 touches no PHY register when its start field (bits 31:30) is not 01 or its PHY address (bits 27:23) is not 1. The word is stored as written with bit 16 set.
- R2: A valid frame with opcode (bits 29:28) 01 writes data bits 15:0 to the PHY register selected by bits 22:18. The stored word is the written word with bit 16 set.
- R3: A valid frame with opcode 10 stores the written word with bits 15:0 replaced by the selected PHY register's contents and bit 16 set.
- R4: A write to PHY register 0 with bit 15 set stores the data with bit 15 cleared and bit 12 set.
- R5: A write to PHY register 0 with bit 9 set stores the data with bit 9 cleared and sets bit 5 of PHY register 1. If link_up is high, it also sets bit 2 of PHY register 1 and bit 8 of PHY register 5.
- R6: After the first clock following reset, any change of link_up copies link_up into bit 2 of PHY register 1 and bit 8 of PHY register 5, and sets the interrupt status (index 3) to 0xFFFF one cycle later.
- R7: The configuration register (index 1, bits 15:0) resets to 0x0100. Bits 9:8 keep their value on writes, and the other bits take the written data.
- R8: A read of index 3 returns the interrupt status and clears it at that clock edge. A link change in the same cycle takes priority.
- R9: irq is high exactly when some interrupt status bit is set whose mask bit (index 2, bits 15:0) is clear. The mask resets to 0xFFFF.
- R10: After reset, PHY register 4 reads 0x0100 and PHY register 1 reads 0x4028. On the first clock after reset, link_up is sampled into bit 2 of register 1 and bit 8 of register 5, and no interrupt is raised.
- R11: A valid frame with opcode 00 or 11 touches no PHY register and is stored with bit 16 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at index 3) |
| reg_addr | input | ADDR_W | Word index: 0 frame, 1 config, 2 mask, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| link_up | input | 1 | Link state of the medium |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives frames with a bad start field, a foreign PHY address and the two idle opcodes, then reads the target register back. A design that decoded such frames loosely would overwrite it. Control-register writes with the reset and restart bits are read back to catch a design that stores those bits instead of clearing them, or sets link ability while the link is down. Link toggles are run with the mask fully closed and with one bit open, to catch an interrupt that ignores the mask. Back-to-back status reads catch a status that fails to clear. Writes of all ones and all zeros to the configuration register expose writable select bits.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int FRAME_W = 32;
  localparam int PREG_W  = 16;
  localparam int RA_W    = 5;

  // frame word fields
  localparam int ST_HI = 31;
  localparam int OP_HI = 29;
  localparam int PA_HI = 27;
  localparam int RA_HI = 22;
  localparam int DONE_BIT = 16;

  // PHY register indices and bits
  localparam int IDX_CTRL = 0;
  localparam int IDX_STS  = 1;
  localparam int IDX_ADV  = 4;
  localparam int IDX_LPA  = 5;
  localparam int CTRL_RST_B   = 15;
  localparam int CTRL_ANEN_B  = 12;
  localparam int CTRL_RSTRT_B = 9;
  localparam int STS_LINK_B   = 2;
  localparam int STS_ANDONE_B = 5;
  localparam int ABIL_TXFD_B  = 8;

  localparam logic [PREG_W-1:0] STS_RST = 16'h4028;
  localparam logic [PREG_W-1:0] ADV_RST = 16'h0100;
  localparam logic [15:0]       CFG_RST = 16'h0100;

  typedef enum logic [1:0] {
    OP_IDLE0 = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_IDLE3 = 2'b11
  } mii_op_e;

  typedef struct packed {
    logic              do_wr;
    logic              do_rd;
    logic [RA_W-1:0]   ra;
    logic [PREG_W-1:0] data;
  } frame_req_t;

  function automatic frame_req_t decode_frame(input logic [FRAME_W-1:0] w,
                                              input logic [4:0] phy);
    frame_req_t r;
    logic hit;
    mii_op_e op;
    hit     = (w[ST_HI -: 2] == 2'b01) && (w[PA_HI -: 5] == phy);
    op      = mii_op_e'(w[OP_HI -: 2]);
    r.do_wr = hit && (op == OP_WRITE);
    r.do_rd = hit && (op == OP_READ);
    r.ra    = w[RA_HI -: RA_W];
    r.data  = w[PREG_W-1:0];
    return r;
  endfunction

  function automatic logic [PREG_W-1:0] ctrl_apply(input logic [PREG_W-1:0] d);
    logic [PREG_W-1:0] r;
    r = d;
    if (d[CTRL_RST_B]) begin
      r[CTRL_RST_B]  = 1'b0;
      r[CTRL_ANEN_B] = 1'b1;
    end
    r[CTRL_RSTRT_B] = 1'b0;
    return r;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_result(input logic [FRAME_W-1:0] w,
                                                      input logic rd,
                                                      input logic [PREG_W-1:0] val);
    logic [FRAME_W-1:0] r;
    r = w;
    if (rd) r[PREG_W-1:0] = val;
    r[DONE_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [PREG_W-1:0] phy_reset_value(input int idx);
    case (idx)
      IDX_STS: return STS_RST;
      IDX_ADV: return ADV_RST;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mii_frame_decoder.sv
module mii_frame_decoder
  import mii_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic [FRAME_W-1:0] word,
  output frame_req_t         req
);
  localparam logic [4:0] PA = 5'(PHY_ADDR);
  assign req = decode_frame(word, PA);
endmodule

// File: rtl/mii_phy_regfile.sv
module mii_phy_regfile
  import mii_mgmt_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  frame_req_t        req,
  input  logic              link_up,
  output logic [PREG_W-1:0] rd_data,
  output logic              link_evt,
  output logic              phy_we,
  output logic [PREG_W-1:0] ctrl_q
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [PREG_W-1:0] regs [NREG];
  logic [PREG_W-1:0] nxt  [NREG];
  logic [PREG_W-1:0] rst_vec [NREG];
  logic primed_q, link_q;
  logic in_range, prime_now;
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < NREG; g++) begin : g_rstval
    assign rst_vec[g] = phy_reset_value(g);
  end

  assign in_range  = {1'b0, req.ra} < (RA_W+1)'(NREG);
  assign idx       = req.ra[IDX_W-1:0];
  assign rd_data   = in_range ? regs[idx] : '0;
  assign prime_now = !primed_q;
  assign link_evt  = primed_q && (link_up != link_q);
  assign phy_we    = req_valid && req.do_wr && in_range;
  assign ctrl_q    = regs[IDX_CTRL];

  always_comb begin
    logic [PREG_W-1:0] d;
    for (int i = 0; i < NREG; i++) nxt[i] = regs[i];
    if (prime_now || link_evt) begin
      nxt[IDX_STS][STS_LINK_B]  = link_up;
      nxt[IDX_LPA][ABIL_TXFD_B] = link_up;
    end
    d = ctrl_apply(req.data);
    if (phy_we) begin
      if (idx == IDX_W'(IDX_CTRL)) begin
        nxt[IDX_CTRL] = d;
        if (req.data[CTRL_RSTRT_B]) begin
          nxt[IDX_STS][STS_ANDONE_B] = 1'b1;
          if (link_up) begin
            nxt[IDX_STS][STS_LINK_B]  = 1'b1;
            nxt[IDX_LPA][ABIL_TXFD_B] = 1'b1;
          end
        end
      end else begin
        nxt[idx] = req.data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_vec[i];
      primed_q <= 1'b0;
      link_q   <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
      primed_q <= 1'b1;
      link_q   <= link_up;
    end
  end
endmodule

// File: rtl/mii_irq_unit.sv
module mii_irq_unit #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic              stat_clr,
  input  logic              stat_set_all,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq
);
  assign irq = |(stat_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      if (stat_set_all)  stat_q <= '1;
      else if (stat_clr) stat_q <= '0;
      if (mask_we) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/mgmt_frame_regs.sv
module mgmt_frame_regs
  import mii_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int NREG     = 32,
  parameter int PHY_ADDR = 1,
  parameter int STAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              link_up,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_FRAME = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(3);

  frame_req_t        req;
  logic              frame_wr;
  logic [PREG_W-1:0] phy_rd;
  logic              link_evt, phy_we;
  logic [PREG_W-1:0] ctrl_q;
  logic [FRAME_W-1:0] frame_q;
  logic [15:0]       cfg_q;
  logic [STAT_W-1:0] stat_q, mask_q;

  assign frame_wr = reg_wr && (reg_addr == A_FRAME);

  mii_frame_decoder #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .word (reg_wdata),
    .req  (req)
  );

  mii_phy_regfile #(.NREG(NREG)) u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (frame_wr),
    .req       (req),
    .link_up   (link_up),
    .rd_data   (phy_rd),
    .link_evt  (link_evt),
    .phy_we    (phy_we),
    .ctrl_q    (ctrl_q)
  );

  mii_irq_unit #(.STAT_W(STAT_W)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_we      (reg_wr && (reg_addr == A_MASK)),
    .mask_wdata   (reg_wdata[STAT_W-1:0]),
    .stat_clr     (reg_rd && (reg_addr == A_STAT)),
    .stat_set_all (link_evt),
    .stat_q       (stat_q),
    .mask_q       (mask_q),
    .irq          (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cfg_q   <= CFG_RST;
    end else begin
      if (frame_wr) frame_q <= frame_result(reg_wdata, req.do_rd, phy_rd);
      if (reg_wr && (reg_addr == A_CFG))
        cfg_q <= {reg_wdata[15:10], cfg_q[9:8], reg_wdata[7:0]};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FRAME: reg_rdata = frame_q;
      A_CFG:   reg_rdata = {16'b0, cfg_q};
      A_MASK:  reg_rdata = 32'(mask_q);
      A_STAT:  reg_rdata = 32'(stat_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mgmt_frame_regs_chk.sv
module mgmt_frame_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        wr_start,
  input logic              link_evt,
  input logic              phy_we,
  input logic [31:0]       frame_q,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [15:0]       cfg_q,
  input logic [15:0]       ctrl_q,
  input logic              irq
);
  a_r1_bad_start_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && wr_start != 2'b01) |-> !phy_we);

  a_r2_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> frame_q[16]);

  a_r4_reset_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[15]);

  a_r5_restart_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[9]);

  a_r6_link_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (stat_q == '1));

  a_r7_select_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_q[9:8]));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(3) && !link_evt) |=> (stat_q == '0));

  a_r9_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
endmodule

bind mgmt_frame_regs mgmt_frame_regs_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .wr_start (reg_wdata[31:30]),
  .link_evt (link_evt),
  .phy_we   (phy_we),
  .frame_q  (frame_q),
  .stat_q   (stat_q),
  .mask_q   (mask_q),
  .cfg_q    (cfg_q),
  .ctrl_q   (ctrl_q),
  .irq      (irq)
);

// File: tb/mgmt_frame_regs_tb_top.sv
`timescale 1ns/1ps
module mgmt_frame_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        link_up = 1'b1;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mgmt_frame_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_up(link_up), .irq(irq)
  );

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {st, op, pa, ra, 2'b00, d};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic mii_write(input logic [4:0] ra, input logic [15:0] d);
    bus_write(2'd0, mk(2'b01, 2'b01, 5'd1, ra, d));
  endtask

  task automatic mii_read(input logic [4:0] ra, output logic [15:0] d);
    logic [31:0] w;
    bus_write(2'd0, mk(2'b01, 2'b10, 5'd1, ra, 16'h0));
    bus_read(2'd0, w);
    d = w[15:0];
  endtask

  task automatic t_reset_state;
    logic [31:0] w; logic [15:0] p;
    bus_read(2'd1, w); check("R7 cfg reset", w, 32'h0000_0100);
    bus_read(2'd2, w); check("R9 mask reset", w, 32'h0000_FFFF);
    bus_read(2'd3, w); check("R10 no start irq", w, 32'h0);
    check("R9 irq idle", {31'b0, irq}, 32'h0);
    bus_read(2'd0, w); check("R1 frame reset", w, 32'h0);
    mii_read(5'd4, p); check("R10 adv reset", {16'b0, p}, 32'h0100);
    mii_read(5'd1, p); check("R10 status reset", {16'b0, p}, 32'h402C);
    mii_read(5'd5, p); check("R10 partner reset", {16'b0, p}, 32'h0100);
  endtask

  task automatic t_write_read;
    logic [31:0] w; logic [31:0] f;
    f = mk(2'b01, 2'b01, 5'd1, 5'd16, 16'hA5C3);
    bus_write(2'd0, f);
    bus_read(2'd0, w); check("R2 write frame word", w, f | 32'h0001_0000);
    f = mk(2'b01, 2'b10, 5'd1, 5'd16, 16'h1234);
    bus_write(2'd0, f);
    bus_read(2'd0, w); check("R3 read frame word", w, {f[31:16] | 16'h0001, 16'hA5C3});
    mii_write(5'd31, 16'h0F0F);
    bus_read(2'd0, w);
    bus_write(2'd0, mk(2'b01, 2'b10, 5'd1, 5'd31, 16'hFFFF));
    bus_read(2'd0, w); check("R3 top register", {16'b0, w[15:0]}, 32'h0F0F);
  endtask

  task automatic t_rejected;
    logic [31:0] w, f; logic [15:0] p;
    f = mk(2'b00, 2'b01, 5'd1, 5'd16, 16'hFFFF);
    bus_write(2'd0, f);
    bus_read(2'd0, w); check("R1 bad start stored", w, f | 32'h0001_0000);
    f = mk(2'b01, 2'b01, 5'd2, 5'd16, 16'h0000);
    bus_write(2'd0, f);
    bus_read(2'd0, w); check("R1 other phy stored", w, f | 32'h0001_0000);
    bus_write(2'd0, mk(2'b11, 2'b01, 5'd1, 5'd16, 16'h5555));
    mii_read(5'd16, p); check("R1 register untouched", {16'b0, p}, 32'hA5C3);
    f = mk(2'b01, 2'b11, 5'd1, 5'd16, 16'h0000);
    bus_write(2'd0, f);
    bus_read(2'd0, w); check("R11 idle op stored", w, f | 32'h0001_0000);
    bus_write(2'd0, mk(2'b01, 2'b00, 5'd1, 5'd16, 16'h7777));
    mii_read(5'd16, p); check("R11 register untouched", {16'b0, p}, 32'hA5C3);
  endtask

  task automatic t_ctrl_reset;
    logic [15:0] p;
    mii_write(5'd0, 16'h8000);
    mii_read(5'd0, p); check("R4 reset self-clears", {16'b0, p}, 32'h1000);
    mii_write(5'd0, 16'h8140);
    mii_read(5'd0, p); check("R4 reset keeps others", {16'b0, p}, 32'h1140);
  endtask

  task automatic t_restart;
    logic [15:0] p; logic [31:0] w;
    mii_write(5'd1, 16'h0000);
    mii_write(5'd5, 16'h0000);
    mii_write(5'd0, 16'h0200);
    mii_read(5'd0, p); check("R5 restart self-clears", {16'b0, p}, 32'h0000);
    mii_read(5'd1, p); check("R5 link up status", {16'b0, p}, 32'h0024);
    mii_read(5'd5, p); check("R5 link up partner", {16'b0, p}, 32'h0100);
    @(negedge clk); link_up = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(2'd3, w);
    mii_write(5'd1, 16'h0000);
    mii_write(5'd5, 16'h0000);
    mii_write(5'd0, 16'h0200);
    mii_read(5'd1, p); check("R5 link down status", {16'b0, p}, 32'h0020);
    mii_read(5'd5, p); check("R5 link down partner", {16'b0, p}, 32'h0000);
  endtask

  task automatic t_link_irq;
    logic [31:0] w; logic [15:0] p;
    bus_read(2'd3, w);
    @(negedge clk); link_up = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 masked irq low", {31'b0, irq}, 32'h0);
    bus_read(2'd3, w); check("R6 status all ones", w, 32'h0000_FFFF);
    bus_read(2'd3, w); check("R8 status cleared", w, 32'h0);
    mii_read(5'd1, p); check("R6 link bit up", {31'b0, p[2]}, 32'h1);
    bus_write(2'd2, 32'h0000_FFFE);
    @(negedge clk); link_up = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    mii_read(5'd5, p); check("R6 partner bit down", {31'b0, p[8]}, 32'h0);
    bus_read(2'd3, w); check("R8 status read", w, 32'h0000_FFFF);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    bus_write(2'd2, 32'h0000_FFFF);
  endtask

  task automatic t_cfg;
    logic [31:0] w;
    bus_write(2'd1, 32'h0000_FFFF);
    bus_read(2'd1, w); check("R7 select bits hold 1", w, 32'h0000_FDFF);
    bus_write(2'd1, 32'h0000_0000);
    bus_read(2'd1, w); check("R7 select bits hold 0", w, 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write_read();
    t_rejected();
    t_ctrl_reset();
    t_restart();
    t_link_irq();
    t_cfg();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule